// File: doc/BRIEF.md
# Host Command Interrupt Controller

This block holds the interrupt logic that sits between an external host processor and a DSP core on a parallel host port. Two single-word data slots carry traffic, one in each direction, and a command vector register lets the host ask the core to run one of 128 interrupt routines. The core sees a control register with three enable bits and a status register with three flags. Each flag, gated by its own enable, drives a separate interrupt request line.

When a command is requested, the core is given an interrupt address equal to twice the 7-bit vector. The request stays pending, with its vector frozen, until the core acknowledges it. A registered fixed-priority stage merges the three request lines into one combined request, a source code and an address. The command takes precedence over receive full, and receive full takes precedence over transmit empty.

Top module: `hcic_top`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `core_ctrl_q` is 0, `core_stat_q` is 3'b010 (transmit slot empty, receive slot not full, no command), `cmd_vec_q` is 0, and `irq_rx`, `irq_tx`, `irq_cmd`, `irq_any`, `irq_src` and `irq_addr` are all 0.
- R2: A core write (`core_ctrl_wr`) loads `core_ctrl_wdata` into the control register, which reads back on `core_ctrl_q` from the next cycle. Bit 0 enables the receive interrupt, bit 1 the transmit interrupt and bit 2 the command interrupt.
- R3: A host data write captures `host_wdata`. From the next cycle the word shows on `core_rx_data` and `core_stat_q[0]` (receive full) is 1. A core read (`core_rx_rd`) clears the flag, and a host write in the same cycle as a core read wins, so the flag stays set. A write while the slot is full overwrites the word.
- R4: A core write (`core_tx_wr`) captures `core_tx_wdata`. From the next cycle the word shows on `host_rdata` and `core_stat_q[1]` (transmit empty) is 0. A host read (`host_rd_data`) sets the flag, and a core write in the same cycle as a host read wins, so the flag stays clear.
- R5: In the command vector register, bit 7 is the request bit and bits 6..0 are the vector. A host write (`host_cmd_wr`) while bit 7 is clear loads all 8 bits. `core_stat_q[2]` (command pending) always equals bit 7 of `cmd_vec_q`.
- R6: While the request bit is set, host writes to the command vector register are ignored, including a write in the same cycle as an acknowledge.
- R7: `core_ack` while a command is pending clears the request bit in the next cycle and keeps the vector bits. `core_ack` with no command pending has no effect.
- R8: `irq_rx`, `irq_tx` and `irq_cmd` each equal their status flag AND their enable bit, in the same cycle as the status register.
- R9: One cycle after the request lines, `irq_any`, `irq_src` and `irq_addr` show the winning request. Priority is command, then receive, then transmit. `irq_src` is 3 for command, 1 for receive, 2 for transmit and 0 for none. `irq_addr` is twice the vector for a command, `RX_VEC_ADDR` (default 8'hF0) for receive, `TX_VEC_ADDR` (default 8'hF2) for transmit, and 0 for none.
- R10: A pending command does not change the data flags or words, and data traffic does not change the command register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_data | input | 1 | Host writes a word toward the core |
| host_wdata | input | DW | Host data word |
| host_rd_data | input | 1 | Host reads the word from the core |
| host_rdata | output | DW | Word written by the core for the host |
| host_cmd_wr | input | 1 | Host write to the command vector register |
| host_cmd_wdata | input | VEC_W+1 | Request bit (MSB) and vector |
| cmd_vec_q | output | VEC_W+1 | Command vector register contents |
| core_ctrl_wr | input | 1 | Core write to the control register |
| core_ctrl_wdata | input | 3 | Enable bits |
| core_ctrl_q | output | 3 | Control register contents |
| core_stat_q | output | 3 | Flags: receive full, transmit empty, command pending |
| core_rx_rd | input | 1 | Core reads the receive word |
| core_rx_data | output | DW | Receive word for the core |
| core_tx_wr | input | 1 | Core writes the transmit word |
| core_tx_wdata | input | DW | Transmit word from the core |
| core_ack | input | 1 | Core acknowledges the command interrupt |
| irq_rx | output | 1 | Receive full interrupt request |
| irq_tx | output | 1 | Transmit empty interrupt request |
| irq_cmd | output | 1 | Host command interrupt request |
| irq_any | output | 1 | Registered: some request active |
| irq_src | output | 2 | Registered source code of the winner |
| irq_addr | output | VEC_W+1 | Registered interrupt address of the winner |

## Verification
The bench targets the same-cycle collisions: a host write against a core read, a core write against a host read, and an acknowledge against a host command write. A design that resolved any of these the other way would lose a word, report an empty slot that holds data, or let a new vector slip in under a pending command. It also drives the extreme vectors 0 and 127, where a missing shift or a dropped bit gives a wrong address. It checks priority with all three requests active, where a wrong order would hand the core a data address while a command waits. Finally, it sets flags while their enables are off and confirms that no request line rises.

// File: rtl/hcic_pkg.sv
package hcic_pkg;
  localparam int NUM_SRC = 3;
  localparam int IDX_RX  = 0;
  localparam int IDX_TX  = 1;
  localparam int IDX_CMD = 2;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RX   = 2'd1,
    SRC_TX   = 2'd2,
    SRC_CMD  = 2'd3
  } irq_src_e;
endpackage

// File: rtl/hcic_slot.sv
module hcic_slot #(
  parameter int DW            = 24,
  parameter bit FLAG_ON_WRITE = 1'b1,
  parameter bit FLAG_RST      = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic          flag,
  output logic [DW-1:0] q
);
  // Writer side owns the word; a write beats a simultaneous read.
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= FLAG_RST;
      q    <= '0;
    end else if (wr) begin
      q    <= wdata;
      flag <= FLAG_ON_WRITE;
    end else if (rd) begin
      flag <= ~FLAG_ON_WRITE;
    end
  end
endmodule

// File: rtl/hcic_cmdvec.sv
module hcic_cmdvec #(
  parameter int VEC_W = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           host_wr,
  input  logic [VEC_W:0] host_wdata,
  input  logic           ack,
  output logic [VEC_W:0] cmd_q,
  output logic           pending
);
  assign pending = cmd_q[VEC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
    end else if (pending) begin
      // vector frozen while pending; only acknowledge drops the request
      if (ack) cmd_q[VEC_W] <= 1'b0;
    end else if (host_wr) begin
      cmd_q <= host_wdata;
    end
  end
endmodule

// File: rtl/hcic_prio.sv
module hcic_prio
  import hcic_pkg::*;
#(
  parameter int VEC_W       = 7,
  parameter int ADDR_W      = VEC_W + 1,
  parameter int RX_VEC_ADDR = 'hF0,
  parameter int TX_VEC_ADDR = 'hF2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req,
  input  logic [VEC_W-1:0]   vec,
  output logic               any_q,
  output logic [1:0]         src_q,
  output logic [ADDR_W-1:0]  addr_q
);
  logic [ADDR_W-1:0] addr_tab [NUM_SRC];
  logic [1:0]        code_tab [NUM_SRC];
  logic [ADDR_W-1:0] nxt_addr;
  logic [1:0]        nxt_src;

  always_comb begin
    addr_tab[IDX_RX]  = ADDR_W'(RX_VEC_ADDR);
    addr_tab[IDX_TX]  = ADDR_W'(TX_VEC_ADDR);
    addr_tab[IDX_CMD] = {vec, 1'b0};
    code_tab[IDX_RX]  = SRC_RX;
    code_tab[IDX_TX]  = SRC_TX;
    code_tab[IDX_CMD] = SRC_CMD;
  end

  // Scan lowest to highest priority so the highest active one is kept.
  localparam int ORDER [NUM_SRC] = '{IDX_TX, IDX_RX, IDX_CMD};

  always_comb begin
    nxt_addr = '0;
    nxt_src  = SRC_NONE;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[ORDER[i]]) begin
        nxt_addr = addr_tab[ORDER[i]];
        nxt_src  = code_tab[ORDER[i]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      any_q  <= 1'b0;
      src_q  <= SRC_NONE;
      addr_q <= '0;
    end else begin
      any_q  <= |req;
      src_q  <= nxt_src;
      addr_q <= nxt_addr;
    end
  end
endmodule

// File: rtl/hcic_top.sv
module hcic_top
  import hcic_pkg::*;
#(
  parameter int DW          = 24,
  parameter int VEC_W       = 7,
  parameter int RX_VEC_ADDR = 'hF0,
  parameter int TX_VEC_ADDR = 'hF2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr_data,
  input  logic [DW-1:0]    host_wdata,
  input  logic             host_rd_data,
  output logic [DW-1:0]    host_rdata,
  input  logic             host_cmd_wr,
  input  logic [VEC_W:0]   host_cmd_wdata,
  output logic [VEC_W:0]   cmd_vec_q,
  input  logic             core_ctrl_wr,
  input  logic [2:0]       core_ctrl_wdata,
  output logic [2:0]       core_ctrl_q,
  output logic [2:0]       core_stat_q,
  input  logic             core_rx_rd,
  output logic [DW-1:0]    core_rx_data,
  input  logic             core_tx_wr,
  input  logic [DW-1:0]    core_tx_wdata,
  input  logic             core_ack,
  output logic             irq_rx,
  output logic             irq_tx,
  output logic             irq_cmd,
  output logic             irq_any,
  output logic [1:0]       irq_src,
  output logic [VEC_W:0]   irq_addr
);
  localparam int ADDR_W = VEC_W + 1;

  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] reqs;
  logic               rx_full, tx_empty, cmd_pend;

  always_ff @(posedge clk) begin
    if (rst)               core_ctrl_q <= '0;
    else if (core_ctrl_wr) core_ctrl_q <= core_ctrl_wdata;
  end

  hcic_slot #(.DW(DW), .FLAG_ON_WRITE(1'b1), .FLAG_RST(1'b0)) rx_slot_i (
    .clk(clk), .rst(rst), .wr(host_wr_data), .wdata(host_wdata),
    .rd(core_rx_rd), .flag(rx_full), .q(core_rx_data)
  );

  hcic_slot #(.DW(DW), .FLAG_ON_WRITE(1'b0), .FLAG_RST(1'b1)) tx_slot_i (
    .clk(clk), .rst(rst), .wr(core_tx_wr), .wdata(core_tx_wdata),
    .rd(host_rd_data), .flag(tx_empty), .q(host_rdata)
  );

  hcic_cmdvec #(.VEC_W(VEC_W)) cmd_i (
    .clk(clk), .rst(rst), .host_wr(host_cmd_wr), .host_wdata(host_cmd_wdata),
    .ack(core_ack), .cmd_q(cmd_vec_q), .pending(cmd_pend)
  );

  assign flags[IDX_RX]  = rx_full;
  assign flags[IDX_TX]  = tx_empty;
  assign flags[IDX_CMD] = cmd_pend;
  assign core_stat_q    = flags;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
    assign reqs[g] = flags[g] & core_ctrl_q[g];
  end

  assign irq_rx  = reqs[IDX_RX];
  assign irq_tx  = reqs[IDX_TX];
  assign irq_cmd = reqs[IDX_CMD];

  hcic_prio #(
    .VEC_W(VEC_W), .ADDR_W(ADDR_W),
    .RX_VEC_ADDR(RX_VEC_ADDR), .TX_VEC_ADDR(TX_VEC_ADDR)
  ) prio_i (
    .clk(clk), .rst(rst), .req(reqs), .vec(cmd_vec_q[VEC_W-1:0]),
    .any_q(irq_any), .src_q(irq_src), .addr_q(irq_addr)
  );
endmodule

// File: rtl/hcic_chk.sv
module hcic_chk #(
  parameter int DW    = 24,
  parameter int VEC_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             host_wr_data,
  input logic [DW-1:0]    host_wdata,
  input logic             host_rd_data,
  input logic [DW-1:0]    host_rdata,
  input logic             host_cmd_wr,
  input logic [VEC_W:0]   host_cmd_wdata,
  input logic [VEC_W:0]   cmd_vec_q,
  input logic             core_ctrl_wr,
  input logic [2:0]       core_ctrl_wdata,
  input logic [2:0]       core_ctrl_q,
  input logic [2:0]       core_stat_q,
  input logic             core_rx_rd,
  input logic [DW-1:0]    core_rx_data,
  input logic             core_tx_wr,
  input logic [DW-1:0]    core_tx_wdata,
  input logic             core_ack,
  input logic             irq_rx,
  input logic             irq_tx,
  input logic             irq_cmd,
  input logic             irq_any,
  input logic [1:0]       irq_src,
  input logic [VEC_W:0]   irq_addr
);
  // R3
  rx_set_chk: assert property (@(posedge clk) disable iff (rst)
    host_wr_data |=> core_stat_q[0] && core_rx_data == $past(host_wdata));

  // R3
  rx_clr_chk: assert property (@(posedge clk) disable iff (rst)
    core_rx_rd && !host_wr_data |=> !core_stat_q[0]);

  // R4
  tx_clr_chk: assert property (@(posedge clk) disable iff (rst)
    core_tx_wr |=> !core_stat_q[1] && host_rdata == $past(core_tx_wdata));

  // R6
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    core_stat_q[2] && !core_ack |=> $stable(cmd_vec_q));

  // R7
  ack_clr_chk: assert property (@(posedge clk) disable iff (rst)
    core_stat_q[2] && core_ack |=>
      !core_stat_q[2] && cmd_vec_q[VEC_W-1:0] == $past(cmd_vec_q[VEC_W-1:0]));

  // R9
  cmd_win_chk: assert property (@(posedge clk) disable iff (rst)
    irq_cmd |=> irq_src == 2'd3 && irq_addr == {$past(cmd_vec_q[VEC_W-1:0]), 1'b0});

  // R8
  any_req_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_rx || irq_tx || irq_cmd) |=> irq_any);
endmodule

bind hcic_top hcic_chk #(.DW(DW), .VEC_W(VEC_W)) chk_i (.*);

// File: tb/hcic_top_tb_top.sv
module hcic_top_tb_top;
  localparam int DW  = 24;
  localparam int VW  = 7;
  localparam logic [7:0] RXA = 8'hF0;
  localparam logic [7:0] TXA = 8'hF2;

  logic clk = 1'b0;
  logic rst;
  logic host_wr_data, host_rd_data, host_cmd_wr;
  logic [DW-1:0] host_wdata, host_rdata;
  logic [VW:0] host_cmd_wdata, cmd_vec_q;
  logic core_ctrl_wr;
  logic [2:0] core_ctrl_wdata, core_ctrl_q, core_stat_q;
  logic core_rx_rd, core_tx_wr, core_ack;
  logic [DW-1:0] core_rx_data, core_tx_wdata;
  logic irq_rx, irq_tx, irq_cmd, irq_any;
  logic [1:0] irq_src;
  logic [VW:0] irq_addr;

  int n_run  = 0;
  int n_fail = 0;

  // bench model
  logic m_rx_full, m_tx_empty;
  logic [DW-1:0] m_rx_data, m_tx_data;
  logic [2:0] m_ctrl;
  logic [7:0] m_cmd;
  logic e_any;
  logic [1:0] e_src;
  logic [7:0] e_addr;

  always #10 clk = ~clk;

  hcic_top dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    host_wr_data = 0; host_rd_data = 0; host_cmd_wr = 0; core_ctrl_wr = 0;
    core_rx_rd = 0; core_tx_wr = 0; core_ack = 0;
  endtask

  task automatic encode(output logic a, output logic [1:0] s, output logic [7:0] ad);
    a = (m_cmd[7] & m_ctrl[2]) | (m_rx_full & m_ctrl[0]) | (m_tx_empty & m_ctrl[1]);
    if (m_cmd[7] & m_ctrl[2])        begin s = 2'd3; ad = {m_cmd[6:0], 1'b0}; end
    else if (m_rx_full & m_ctrl[0])  begin s = 2'd1; ad = RXA; end
    else if (m_tx_empty & m_ctrl[1]) begin s = 2'd2; ad = TXA; end
    else                             begin s = 2'd0; ad = 8'h00; end
  endtask

  task automatic check_all();
    chk("R2 ctrl", core_ctrl_q, m_ctrl);
    chk("R3 full", core_stat_q[0], m_rx_full);
    chk("R3 data", core_rx_data, m_rx_data);
    chk("R4 empty", core_stat_q[1], m_tx_empty);
    chk("R4 data", host_rdata, m_tx_data);
    chk("R5 cmd", cmd_vec_q, m_cmd);
    chk("R5 pend", core_stat_q[2], m_cmd[7]);
    chk("R8 lines", {irq_cmd, irq_tx, irq_rx},
        {m_cmd[7] & m_ctrl[2], m_tx_empty & m_ctrl[1], m_rx_full & m_ctrl[0]});
    chk("R9 prio", {irq_any, irq_src, irq_addr}, {e_any, e_src, e_addr});
  endtask

  // inputs are set at a falling edge; this takes one rising edge and checks at the next fall
  task automatic step();
    logic a; logic [1:0] s; logic [7:0] ad;
    encode(a, s, ad);
    @(posedge clk);
    if (rst) begin
      m_rx_full = 0; m_tx_empty = 1; m_rx_data = '0; m_tx_data = '0;
      m_ctrl = '0; m_cmd = '0; e_any = 0; e_src = 0; e_addr = 0;
    end else begin
      e_any = a; e_src = s; e_addr = ad;
      if (host_wr_data) begin m_rx_full = 1; m_rx_data = host_wdata; end
      else if (core_rx_rd) m_rx_full = 0;
      if (core_tx_wr) begin m_tx_empty = 0; m_tx_data = core_tx_wdata; end
      else if (host_rd_data) m_tx_empty = 1;
      if (core_ctrl_wr) m_ctrl = core_ctrl_wdata;
      if (m_cmd[7]) begin
        if (core_ack) m_cmd[7] = 1'b0;
      end else if (host_cmd_wr) m_cmd = host_cmd_wdata;
    end
    @(negedge clk);
    check_all();
    idle();
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_rx_full = 0; m_tx_empty = 1; m_rx_data = '0; m_tx_data = '0;
    m_ctrl = '0; m_cmd = '0; e_any = 0; e_src = 0; e_addr = 0;
    idle();
    host_wdata = '0; host_cmd_wdata = '0; core_ctrl_wdata = '0; core_tx_wdata = '0;
    rst = 1;
    @(negedge clk);
    step(); step();
    // R1 reset state
    chk("R1 stat", core_stat_q, 3'b010);
    chk("R1 ctrl", core_ctrl_q, 3'b000);
    chk("R1 cmd", cmd_vec_q, 8'h00);
    chk("R1 irq", {irq_rx, irq_tx, irq_cmd, irq_any, irq_src, irq_addr}, 0);
    rst = 0;

    // enable everything
    core_ctrl_wr = 1; core_ctrl_wdata = 3'b111; step();
    chk("R2 enables", core_ctrl_q, 3'b111);

    // R10: command and data in the same cycle, vector 127
    host_cmd_wr = 1; host_cmd_wdata = 8'hFF; host_wr_data = 1; host_wdata = 24'hA5A5A5;
    step();
    chk("R10 flags", core_stat_q, 3'b111);
    chk("R10 data", core_rx_data, 24'hA5A5A5);
    step();
    chk("R9 addr max", irq_addr, 8'hFE);
    chk("R9 cmd wins", irq_src, 2'd3);

    // R6: write while pending
    host_cmd_wr = 1; host_cmd_wdata = 8'h85; step();
    chk("R6 ignored", cmd_vec_q, 8'hFF);

    // R7: acknowledge
    core_ack = 1; step();
    chk("R7 cleared", cmd_vec_q, 8'h7F);
    chk("R10 rx kept", core_stat_q[0], 1'b1);
    step();
    chk("R9 rx next", {irq_src, irq_addr}, {2'd1, RXA});
    core_ack = 1; step();
    chk("R7 no pend ack", cmd_vec_q, 8'h7F);

    // vector 0
    host_cmd_wr = 1; host_cmd_wdata = 8'h80; step(); step();
    chk("R9 addr zero", {irq_src, irq_addr}, {2'd3, 8'h00});

    // R6: ack and write together while pending
    core_ack = 1; host_cmd_wr = 1; host_cmd_wdata = 8'h91; step();
    chk("R6 ack+write", cmd_vec_q, 8'h00);

    // R3 collision
    host_wr_data = 1; host_wdata = 24'h123456; core_rx_rd = 1; step();
    chk("R3 write wins", {core_stat_q[0], core_rx_data}, {1'b1, 24'h123456});
    core_rx_rd = 1; step();
    chk("R3 read clears", core_stat_q[0], 1'b0);

    // R4 collision
    core_tx_wr = 1; core_tx_wdata = 24'h0F0F0F; host_rd_data = 1; step();
    chk("R4 write wins", {core_stat_q[1], host_rdata}, {1'b0, 24'h0F0F0F});
    step();
    chk("R9 none", {irq_any, irq_src, irq_addr}, 0);
    host_rd_data = 1; step();
    chk("R4 read sets", core_stat_q[1], 1'b1);

    // R8: flags with enables off
    core_ctrl_wr = 1; core_ctrl_wdata = 3'b000; host_wr_data = 1; host_wdata = 24'h1;
    step();
    host_cmd_wr = 1; host_cmd_wdata = 8'h8C; step(); step();
    chk("R8 masked", {irq_rx, irq_tx, irq_cmd, irq_any}, 4'b0000);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      host_wr_data    = ($urandom % 4) == 0;
      host_wdata      = DW'($urandom);
      host_rd_data    = ($urandom % 4) == 0;
      host_cmd_wr     = ($urandom % 5) == 0;
      host_cmd_wdata  = 8'($urandom);
      core_ctrl_wr    = ($urandom % 9) == 0;
      core_ctrl_wdata = 3'($urandom);
      core_rx_rd      = ($urandom % 3) == 0;
      core_tx_wr      = ($urandom % 3) == 0;
      core_tx_wdata   = DW'($urandom);
      core_ack        = ($urandom % 4) == 0;
      step();
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule